// File: doc/BRIEF.md
# Dual-Issue Pairing Decision

This block sits in the decode stage of an in-order core that can start two instructions per cycle on two unequal pipes, called U and V. Each cycle it looks at the two oldest decoded instructions in program order, the older one and the younger one. For each instruction it receives four things: an opcode class, the source register identifiers with their valid bits, a destination register with its write enable, and a sub-register field. The sub-register field says whether the instruction touches the whole register, only its low byte, or only its high byte.

The block decides whether both instructions start together or whether only the older one starts. When both start, the older one goes to U and the younger one goes to V. When only the older one starts, it goes to U and the younger one stays behind to become the older slot of the next cycle. The decision is registered. It comes out as an issue count, a flag saying the V pipe is used, and a reason code that explains why pairing was refused.

Top module: `pair_issue_check`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it, `issue_cnt`, `v_used` and `why` are all zero.
- R2: If the older slot is not valid, the issue count is 0 and the reason is 0. If the older slot is valid and the younger slot is not, the issue count is 1 and the reason is 0.
- R3: A valid pair with no refusal gives an issue count of 2, `v_used`=1 and reason 0 (none). A refused pair gives an issue count of 1 and `v_used`=0.
- R4: Read-after-write. If an enabled younger source equals the older destination, the older write is enabled, and the two sub-register byte masks overlap, the pair is refused with reason 1. The masks are: field 0 = both bytes, 1 = low byte, 2 = high byte, 3 = both bytes.
- R5: Write-after-write. If both writes are enabled to the same register with overlapping byte masks, the pair is refused with reason 2.
- R6: Partial register. If both writes are enabled to the same register with disjoint byte masks (one low byte, one high byte), the pair is refused with reason 3.
- R7: Opcode class 3 marks an instruction that may never pair. If either instruction has class 3, the pair is refused with reason 4.
- R8: Class 0 may use either pipe, class 1 is U-only and class 2 is V-only. If the older instruction is V-only or the younger one is U-only, the pair is refused with reason 5.
- R9: When several refusals apply, the reported reason is the first match in this order: RAW, WAW, partial, never-pair, pipe class.
- R10: Every result appears on the outputs exactly one clock edge after the inputs that produced it are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| old_vld | input | 1 | Older slot holds an instruction |
| old_cls | input | 2 | Older opcode class (0 either, 1 U-only, 2 V-only, 3 never-pair) |
| old_part | input | 2 | Older sub-register field |
| old_dst | input | REG_W | Older destination register |
| old_wr | input | 1 | Older writes its destination |
| yng_vld | input | 1 | Younger slot holds an instruction |
| yng_cls | input | 2 | Younger opcode class |
| yng_part | input | 2 | Younger sub-register field |
| yng_src | input | NUM_SRC*REG_W | Younger source registers, source k in bits [k*REG_W +: REG_W] |
| yng_src_vld | input | NUM_SRC | Younger source enables |
| yng_dst | input | REG_W | Younger destination register |
| yng_wr | input | 1 | Younger writes its destination |
| issue_cnt | output | 2 | Instructions started this cycle (0, 1 or 2) |
| v_used | output | 1 | Younger instruction goes to the V pipe |
| why | output | 3 | Reason code: 0 none, 1 RAW, 2 WAW, 3 partial, 4 never-pair, 5 pipe class |

## Verification
Every output is due one clock edge after the inputs that produce it are sampled. The bench drives a slot pair on a falling edge, lets one rising edge pass, and compares all three outputs on the next falling edge against a model computed from the inputs it drove. The reset check samples the first falling edge after an edge taken with reset asserted. The bound properties use the same one-edge spacing: each antecedent on the inputs implies its consequent on the outputs with `|=>`.

// File: rtl/dual_pair_pkg.sv
package dual_pair_pkg;

   // Opcode classes: which pipe an instruction may use.
   typedef enum logic [1:0] {
      CLS_ANY  = 2'd0,
      CLS_U    = 2'd1,
      CLS_V    = 2'd2,
      CLS_SOLO = 2'd3
   } op_cls_e;

   // Refusal reasons, listed in priority order (first match wins).
   typedef enum logic [2:0] {
      RSN_NONE = 3'd0,
      RSN_RAW  = 3'd1,
      RSN_WAW  = 3'd2,
      RSN_PART = 3'd3,
      RSN_SOLO = 3'd4,
      RSN_PIPE = 3'd5
   } rsn_e;

   // Sub-register field to byte mask: bit 0 = low byte, bit 1 = high byte.
   function automatic logic [1:0] byte_mask(input logic [1:0] part);
      case (part)
         2'd1:    byte_mask = 2'b01;
         2'd2:    byte_mask = 2'b10;
         default: byte_mask = 2'b11;
      endcase
   endfunction

endpackage

// File: rtl/dp_src_hit.sv
// Read-after-write detection: each younger source is compared against the
// older destination.
module dp_src_hit #(
   parameter int REG_W   = 3,
   parameter int NUM_SRC = 2
) (
   input  logic [REG_W-1:0]         old_dst,
   input  logic                     old_wr,
   input  logic [1:0]               old_part,
   input  logic [NUM_SRC*REG_W-1:0] yng_src,
   input  logic [NUM_SRC-1:0]       yng_src_vld,
   input  logic [1:0]               yng_part,
   output logic                     raw_hit
);
   import dual_pair_pkg::*;

   logic [NUM_SRC-1:0] per_src;
   logic               lanes_meet;

   assign lanes_meet = |(byte_mask(old_part) & byte_mask(yng_part));

   // One comparator per source.
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign per_src[k] = yng_src_vld[k] && old_wr && lanes_meet &&
                          (yng_src[k*REG_W +: REG_W] == old_dst);
   end

   assign raw_hit = |per_src;
endmodule

// File: rtl/dp_dst_cmp.sv
// Destination comparison: a full (WAW) conflict or a split-byte conflict.
module dp_dst_cmp #(
   parameter int REG_W = 3
) (
   input  logic [REG_W-1:0] old_dst,
   input  logic             old_wr,
   input  logic [1:0]       old_part,
   input  logic [REG_W-1:0] yng_dst,
   input  logic             yng_wr,
   input  logic [1:0]       yng_part,
   output logic             waw_hit,
   output logic             part_hit
);
   import dual_pair_pkg::*;

   logic same_reg;
   logic overlap;

   assign same_reg = old_wr && yng_wr && (old_dst == yng_dst);
   assign overlap  = |(byte_mask(old_part) & byte_mask(yng_part));
   assign waw_hit  = same_reg && overlap;
   assign part_hit = same_reg && !overlap;
endmodule

// File: rtl/dp_class_rule.sv
// Class rules: never-pair opcodes and the pipe asymmetry.
module dp_class_rule (
   input  logic [1:0] old_cls,
   input  logic [1:0] yng_cls,
   output logic       solo_hit,
   output logic       pipe_hit
);
   import dual_pair_pkg::*;

   op_cls_e oc, yc;

   assign oc       = op_cls_e'(old_cls);
   assign yc       = op_cls_e'(yng_cls);
   assign solo_hit = (oc == CLS_SOLO) || (yc == CLS_SOLO);
   // The older instruction always takes U, so it must not be V-only,
   // and the younger one takes V, so it must not be U-only.
   assign pipe_hit = (oc == CLS_V) || (yc == CLS_U);
endmodule

// File: rtl/dp_reason_pick.sv
// Priority selection among the refusal causes.
module dp_reason_pick (
   input  logic       raw_hit,
   input  logic       waw_hit,
   input  logic       part_hit,
   input  logic       solo_hit,
   input  logic       pipe_hit,
   output logic [2:0] reason
);
   import dual_pair_pkg::*;

   always_comb begin
      if (raw_hit)       reason = RSN_RAW;
      else if (waw_hit)  reason = RSN_WAW;
      else if (part_hit) reason = RSN_PART;
      else if (solo_hit) reason = RSN_SOLO;
      else if (pipe_hit) reason = RSN_PIPE;
      else               reason = RSN_NONE;
   end
endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check #(
   parameter int REG_W   = 3,
   parameter int NUM_SRC = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     old_vld,
   input  logic [1:0]               old_cls,
   input  logic [1:0]               old_part,
   input  logic [REG_W-1:0]         old_dst,
   input  logic                     old_wr,
   input  logic                     yng_vld,
   input  logic [1:0]               yng_cls,
   input  logic [1:0]               yng_part,
   input  logic [NUM_SRC*REG_W-1:0] yng_src,
   input  logic [NUM_SRC-1:0]       yng_src_vld,
   input  logic [REG_W-1:0]         yng_dst,
   input  logic                     yng_wr,
   output logic [1:0]               issue_cnt,
   output logic                     v_used,
   output logic [2:0]               why
);
   import dual_pair_pkg::*;

   initial begin
      if (REG_W < 1 || REG_W > 8)
         $error("pair_issue_check: REG_W must be in 1..8");
      if (NUM_SRC < 1 || NUM_SRC > 4)
         $error("pair_issue_check: NUM_SRC must be in 1..4");
   end

   logic       raw_hit, waw_hit, part_hit, solo_hit, pipe_hit;
   logic [2:0] pair_rsn;
   logic [1:0] cnt_nx;
   logic [2:0] why_nx;

   dp_src_hit #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_src (
      .old_dst(old_dst), .old_wr(old_wr), .old_part(old_part),
      .yng_src(yng_src), .yng_src_vld(yng_src_vld), .yng_part(yng_part),
      .raw_hit(raw_hit)
   );

   dp_dst_cmp #(.REG_W(REG_W)) i_dst (
      .old_dst(old_dst), .old_wr(old_wr), .old_part(old_part),
      .yng_dst(yng_dst), .yng_wr(yng_wr), .yng_part(yng_part),
      .waw_hit(waw_hit), .part_hit(part_hit)
   );

   dp_class_rule i_cls (
      .old_cls(old_cls), .yng_cls(yng_cls),
      .solo_hit(solo_hit), .pipe_hit(pipe_hit)
   );

   dp_reason_pick i_pick (
      .raw_hit(raw_hit), .waw_hit(waw_hit), .part_hit(part_hit),
      .solo_hit(solo_hit), .pipe_hit(pipe_hit), .reason(pair_rsn)
   );

   always_comb begin
      if (!old_vld) begin
         cnt_nx = 2'd0;
         why_nx = RSN_NONE;
      end else if (!yng_vld) begin
         cnt_nx = 2'd1;
         why_nx = RSN_NONE;
      end else begin
         why_nx = pair_rsn;
         cnt_nx = (pair_rsn == RSN_NONE) ? 2'd2 : 2'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_cnt <= 2'd0;
         v_used    <= 1'b0;
         why       <= 3'd0;
      end else begin
         issue_cnt <= cnt_nx;
         v_used    <= (cnt_nx == 2'd2);
         why       <= why_nx;
      end
   end
endmodule

// File: rtl/pair_issue_check_sva.sv
module pair_issue_check_sva #(
   parameter int REG_W   = 3,
   parameter int NUM_SRC = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       old_vld,
   input logic [1:0] old_cls,
   input logic       yng_vld,
   input logic [1:0] yng_cls,
   input logic [1:0] issue_cnt,
   input logic       v_used,
   input logic [2:0] why
);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !old_vld |=> (issue_cnt == 2'd0 && why == 3'd0));

   p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (old_vld && !yng_vld) |=> (issue_cnt == 2'd1 && why == 3'd0));

   p_pair_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_cnt == 2'd2) |-> (v_used && why == 3'd0));

   p_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (why != 3'd0) |-> (issue_cnt == 2'd1 && !v_used));

   p_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (old_vld && yng_vld && (old_cls == 2'd3 || yng_cls == 2'd3))
      |=> (issue_cnt == 2'd1 && why != 3'd0 && why <= 3'd4));

   p_pipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (old_vld && yng_vld && (old_cls == 2'd2 || yng_cls == 2'd1))
      |=> (issue_cnt == 2'd1 && why != 3'd0));

   p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      why <= 3'd5);
endmodule

bind pair_issue_check pair_issue_check_sva #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_sva (
   .clk(clk), .rst_n(rst_n), .old_vld(old_vld), .old_cls(old_cls),
   .yng_vld(yng_vld), .yng_cls(yng_cls), .issue_cnt(issue_cnt),
   .v_used(v_used), .why(why)
);

// File: tb/test_pair_issue_check.sv
module test_pair_issue_check;
   localparam int REG_W   = 3;
   localparam int NUM_SRC = 2;

   logic                     clk = 1'b0;
   logic                     rst_n;
   logic                     old_vld, old_wr, yng_vld, yng_wr;
   logic [1:0]               old_cls, old_part, yng_cls, yng_part;
   logic [REG_W-1:0]         old_dst, yng_dst;
   logic [NUM_SRC*REG_W-1:0] yng_src;
   logic [NUM_SRC-1:0]       yng_src_vld;
   logic [1:0]               issue_cnt;
   logic                     v_used;
   logic [2:0]               why;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   pair_issue_check #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_pair_issue_check (
      .clk(clk), .rst_n(rst_n),
      .old_vld(old_vld), .old_cls(old_cls), .old_part(old_part),
      .old_dst(old_dst), .old_wr(old_wr),
      .yng_vld(yng_vld), .yng_cls(yng_cls), .yng_part(yng_part),
      .yng_src(yng_src), .yng_src_vld(yng_src_vld),
      .yng_dst(yng_dst), .yng_wr(yng_wr),
      .issue_cnt(issue_cnt), .v_used(v_used), .why(why)
   );

   function automatic int mask_of(input int p);
      if (p == 1) return 1;
      if (p == 2) return 2;
      return 3;
   endfunction

   // Reference model: returns count*16 + reason.
   function automatic int model();
      int  meet;
      bit  raw;
      int  rsn;
      if (!old_vld) return 0;
      if (!yng_vld) return 16;
      meet = mask_of(int'(old_part)) & mask_of(int'(yng_part));
      raw = 0;
      for (int k = 0; k < NUM_SRC; k++)
         if (yng_src_vld[k] && old_wr && meet != 0 &&
             int'(yng_src[k*REG_W +: REG_W]) == int'(old_dst)) raw = 1;
      if (raw) rsn = 1;
      else if (old_wr && yng_wr && old_dst == yng_dst && meet != 0) rsn = 2;
      else if (old_wr && yng_wr && old_dst == yng_dst) rsn = 3;
      else if (old_cls == 2'd3 || yng_cls == 2'd3) rsn = 4;
      else if (old_cls == 2'd2 || yng_cls == 2'd1) rsn = 5;
      else rsn = 0;
      return (rsn == 0) ? 32 : (16 + rsn);
   endfunction

   task automatic idle_inputs();
      old_vld = 0; old_cls = 0; old_part = 0; old_dst = 0; old_wr = 0;
      yng_vld = 0; yng_cls = 0; yng_part = 0; yng_src = '0;
      yng_src_vld = '0; yng_dst = 0; yng_wr = 0;
   endtask

   // Inputs are already set; the result is due one edge later (R10).
   task automatic step_check(input string tag);
      int exp, ec, er;
      exp = model();
      ec = exp / 16;
      er = exp % 16;
      @(posedge clk);
      @(negedge clk);
      total++;
      if (int'(issue_cnt) != ec || int'(why) != er || v_used != (ec == 2)) begin
         bad++;
         $display("FAIL %s: cnt=%0d v=%0d why=%0d expected cnt=%0d v=%0d why=%0d",
                  tag, issue_cnt, v_used, why, ec, (ec == 2), er);
      end
   endtask

   task automatic set_pair(input int oc, input int op, input int od, input int ow,
                           input int yc, input int yp, input int s0, input int s1,
                           input int sv, input int yd, input int yw);
      old_vld = 1; old_cls = 2'(oc); old_part = 2'(op); old_dst = REG_W'(od);
      old_wr = 1'(ow);
      yng_vld = 1; yng_cls = 2'(yc); yng_part = 2'(yp);
      yng_src = {REG_W'(s1), REG_W'(s0)}; yng_src_vld = NUM_SRC'(sv);
      yng_dst = REG_W'(yd); yng_wr = 1'(yw);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed;
      idle_inputs();
      rst_n = 0;
      set_pair(0, 0, 1, 1, 0, 0, 2, 3, 3, 4, 1);
      @(posedge clk);
      @(negedge clk);
      total++;
      if (issue_cnt != 0 || why != 0 || v_used != 0) begin
         bad++;
         $display("FAIL R1 reset: cnt=%0d v=%0d why=%0d expected 0 0 0",
                  issue_cnt, v_used, why);
      end
      rst_n = 1;

      idle_inputs();                               step_check("R2 older empty");
      old_vld = 1;                                 step_check("R2 younger empty");
      set_pair(0, 0, 1, 1, 0, 0, 2, 3, 3, 4, 1);   step_check("R3 clean pair");
      set_pair(1, 0, 1, 1, 2, 0, 5, 6, 3, 7, 0);   step_check("R3 U-only then V-only");
      set_pair(0, 0, 1, 1, 0, 0, 2, 1, 3, 4, 1);   step_check("R4 RAW on source 1");
      set_pair(0, 1, 1, 1, 0, 2, 1, 2, 1, 4, 1);   step_check("R4 disjoint bytes no RAW");
      set_pair(0, 0, 1, 1, 0, 0, 1, 2, 2, 4, 1);   step_check("R4 disabled source ignored");
      set_pair(0, 0, 5, 1, 0, 1, 2, 3, 3, 5, 1);   step_check("R5 WAW");
      set_pair(0, 1, 5, 1, 0, 2, 2, 3, 3, 5, 1);   step_check("R6 low/high partial");
      set_pair(3, 0, 1, 1, 0, 0, 2, 3, 3, 4, 1);   step_check("R7 older never-pair");
      set_pair(0, 0, 1, 1, 3, 0, 2, 3, 3, 4, 1);   step_check("R7 younger never-pair");
      set_pair(2, 0, 1, 1, 0, 0, 2, 3, 3, 4, 1);   step_check("R8 older V-only");
      set_pair(0, 0, 1, 1, 1, 0, 2, 3, 3, 4, 1);   step_check("R8 younger U-only");
      set_pair(3, 0, 1, 1, 1, 0, 1, 3, 1, 1, 1);   step_check("R9 RAW beats all");
      set_pair(3, 2, 4, 1, 1, 1, 2, 3, 3, 4, 1);   step_check("R9 partial beats class");
      set_pair(3, 0, 1, 0, 1, 0, 2, 3, 3, 4, 1);   step_check("R9 never-pair beats pipe");

      seed = 32'h1234_5677;
      for (int n = 0; n < 400; n++) begin
         seed = seed * 1103515245 + 12345;
         old_vld = (seed[20:18] != 0); old_cls = seed[3:2]; old_part = seed[5:4];
         old_dst = seed[8:6]; old_wr = seed[9];
         seed = seed * 1103515245 + 12345;
         yng_vld = (seed[22:20] != 0); yng_cls = seed[3:2]; yng_part = seed[5:4];
         yng_src = seed[11:6]; yng_src_vld = seed[13:12];
         yng_dst = seed[16:14]; yng_wr = seed[17];
         step_check("R10 random stream");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule